// File: doc/BRIEF.md
# Chopping Weight Bit-Stream Generator

This block turns an unsigned binary fraction into a serial bit stream for bit-serial multiplication. The fraction of set bits in one stream period equals the value. A free-running position counter sweeps the period. A bank of basic chopping signals decodes that counter. Basic signal k has 2^(W-1-k) set bits per period. These signals never overlap, and each one spaces its set bits evenly across the period. Each magnitude bit enables one basic signal, and the output is the OR of the enabled signals. The count of ones in a period therefore equals the magnitude exactly, and the ones stay spread out rather than bunched together.

The magnitude is captured once per period, at the boundary, so changing it in mid-stream cannot corrupt the count. A pulse marks the first cycle of every period. A restart input forces a new period to begin, which lets several generators be brought into step. The stream length is 2^W for a magnitude width W: 256 by default, and 32 with W = 5. The value 1.0 cannot be represented; the largest value is (2^W-1)/2^W.

Top module: `chop_stream_gen`

## Requirements
- R1: While reset is held, `period_start` is 1 and `stream_out` is 0. The first cycle after reset release is position 0. The first period after reset uses a magnitude of 0, whatever `magnitude` is driving.
- R2: Over every complete period, the number of cycles with `stream_out` = 1 equals the magnitude that was captured for that period. This holds for every value from 0 to 2^W-1.
- R3: The basic chopping signals never overlap. With all magnitude bits set, the stream is 1 at every position except the last one (position 2^W-1).
- R4: A magnitude of exactly one half (only the MSB set) gives a stream that is 1 at every even position and 0 at every odd position.
- R5: A magnitude with a single bit set, of value v, gives ones spaced exactly S = 2^W/v cycles apart. The first one falls at position S/2-1.
- R6: `period_start` is 1 exactly on position 0 of each period. When no restart occurs it repeats every 2^W cycles.
- R7: `magnitude` is captured only in the cycle at position 2^W-1, or in a restart cycle. A change at any other time does not affect the current period; it takes effect from the next period.
- R8: When `sync_restart` is 1, the next cycle is position 0 (`period_start` = 1). That new period uses the `magnitude` value that was present during the restart cycle.
- R9: A captured magnitude of 0 keeps `stream_out` at 0 for the whole period.
- R10: With W = 5, the period is 32 cycles and R2 and R6 hold for all 32 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| magnitude | input | MAG_W | Unsigned fraction; value = magnitude / 2^MAG_W |
| sync_restart | input | 1 | Forces position 0 on the next cycle and captures `magnitude` |
| period_start | output | 1 | High on position 0 of each period |
| stream_out | output | 1 | Encoded serial bit stream |

## Verification
The bench goes after six corner cases:
- **Full sweep.** Every magnitude is counted over a whole period. A wrong bit order between magnitude and pattern, or overlapping patterns, would give the wrong count.
- **All ones and half scale.** These check where the ones fall. A design whose patterns overlap, or that clusters its ones, would put them in the wrong places.
- **Mid-period change.** The bench changes the magnitude during a period. A design that samples the magnitude continuously would count a blend of the two values.
- **Reset.** A design that captures the magnitude during reset would emit ones in the first period.
- **Restart.** A restart is issued part-way through a period. A design that ignores the restart, or fails to capture with it, would misplace the period pulse or the count.
- **Short stream.** A 32-cycle instance guards against widths that are hard-coded to the default.

// File: rtl/chop_pkg.sv
// Package: shared defaults for the chopping stream generator.
// Assumes: nothing; holds constants only.
package chop_pkg;
    // Default magnitude width; the stream is 2**width cycles long.
    localparam int unsigned CHOP_DEFAULT_W = 8;
endpackage

// File: rtl/chop_pos_counter.sv
// Module: free-running position counter across one stream period.
// Wraps from all ones to zero. A restart forces zero on the next cycle.
// Assumes: synchronous active-low reset; W >= 2.
module chop_pos_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] pos,
    output logic         last_pos
);
    localparam logic [W-1:0] POS_MAX = {W{1'b1}};

    // Advance the position; reset or restart returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos <= '0;
        end else begin
            pos <= pos + W'(1);
        end
    end

    // Flag the final position of the period.
    assign last_pos = (pos == POS_MAX);
endmodule

// File: rtl/chop_mag_hold.sv
// Module: holds the magnitude for a whole period.
// Loads at the period boundary or on restart, and clears to zero in reset.
// Assumes: load is high for exactly the cycles before a new period.
module chop_mag_hold #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] mag_in,
    output logic [W-1:0] mag_q
);
    // Capture the magnitude only when a new period is about to begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
        end else if (load) begin
            mag_q <= mag_in;
        end
    end
endmodule

// File: rtl/chop_pattern_bank.sv
// Module: decodes the position into W disjoint basic chopping signals.
// Signal k fires when the low k bits of pos are all ones and bit k is zero.
// That gives 2**(W-1-k) evenly spaced ones per period.
// Assumes: pos counts upward through the period.
module chop_pattern_bank #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] pos,
    output logic [W-1:0] basic
);
    // One decoder per basic signal; slot 0 needs no low-bit term.
    for (genvar k = 0; k < W; k++) begin : g_slot
        if (k == 0) begin : g_first
            assign basic[k] = ~pos[0];
        end else begin : g_rest
            assign basic[k] = (&pos[k-1:0]) & ~pos[k];
        end
    end
endmodule

// File: rtl/chop_stream_gen.sv
// Module: top of the chopping weight bit-stream generator.
// ORs the basic signals enabled by the held magnitude. Magnitude bit W-1-k
// enables signal k, so the ones per period equal the magnitude.
// Assumes: synchronous active-low reset; outputs are decoded from registers.
module chop_stream_gen
    import chop_pkg::*;
#(
    parameter int unsigned MAG_W = CHOP_DEFAULT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] magnitude,
    input  logic             sync_restart,
    output logic             period_start,
    output logic             stream_out
);
    logic [MAG_W-1:0] pos_q;
    logic             last_pos;
    logic [MAG_W-1:0] mag_q;
    logic [MAG_W-1:0] basic_sig;
    logic [MAG_W-1:0] enable_sig;

    chop_pos_counter #(.W(MAG_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (sync_restart),
        .pos      (pos_q),
        .last_pos (last_pos)
    );

    chop_mag_hold #(.W(MAG_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (last_pos | sync_restart),
        .mag_in (magnitude),
        .mag_q  (mag_q)
    );

    chop_pattern_bank #(.W(MAG_W)) u_bank (
        .pos   (pos_q),
        .basic (basic_sig)
    );

    // Map magnitude bits onto slots: the MSB drives the densest pattern.
    for (genvar k = 0; k < MAG_W; k++) begin : g_map
        assign enable_sig[k] = basic_sig[k] & mag_q[MAG_W-1-k];
    end

    // Union of the enabled patterns forms the stream.
    assign stream_out   = |enable_sig;
    // Mark position zero of each period.
    assign period_start = (pos_q == '0);
endmodule

// File: rtl/chop_stream_gen_chk.sv
// Module: assertion checker for chop_stream_gen, attached with bind.
// Assumes: it can see the position, the held magnitude and the basic signals.
module chop_stream_gen_chk #(
    parameter int unsigned MAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_restart,
    input logic             period_start,
    input logic             stream_out,
    input logic [MAG_W-1:0] position,
    input logic [MAG_W-1:0] mag_held,
    input logic [MAG_W-1:0] basic_sig
);
    logic [MAG_W:0] ones_acc;
    logic [MAG_W:0] ones_now;

    // Running count of ones within the current period.
    assign ones_now = (period_start ? '0 : ones_acc) + (MAG_W+1)'(stream_out);

    // Hold the running count between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) ones_acc <= '0;
        else        ones_acc <= ones_now;
    end

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (period_start && !stream_out));

    // R2
    period_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (position == {MAG_W{1'b1}}) |-> (ones_now == {1'b0, mag_held}));

    // R3
    disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(basic_sig));

    // R6
    wrap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (position == {MAG_W{1'b1}} && !sync_restart) |=> period_start);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && !sync_restart) |=> !period_start);

    // R7
    mag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (position != {MAG_W{1'b1}} && !sync_restart) |=> $stable(mag_held));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_restart |=> period_start);

    // R9
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_held == '0) |-> !stream_out);
endmodule

bind chop_stream_gen chop_stream_gen_chk #(.MAG_W(MAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_restart (sync_restart),
    .period_start (period_start),
    .stream_out   (stream_out),
    .position     (pos_q),
    .mag_held     (mag_q),
    .basic_sig    (basic_sig)
);

// File: tb/chop_stream_gen_bench.sv
// Bench: directed scenarios on a 256-long instance and a 32-long instance.
module chop_stream_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] magnitude = 8'hFF;
    logic       sync_restart = 1'b0;
    logic       period_start;
    logic       stream_out;
    logic [4:0] mag5 = '0;
    logic       ps5;
    logic       so5;
    int         checks = 0;
    int         fails = 0;
    int         cycles = 0;

    always #4 clk = ~clk;

    chop_stream_gen u_chop_stream_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .magnitude    (magnitude),
        .sync_restart (sync_restart),
        .period_start (period_start),
        .stream_out   (stream_out)
    );

    chop_stream_gen #(.MAG_W(5)) u_chop_stream_gen_w5 (
        .clk          (clk),
        .rst_n        (rst_n),
        .magnitude    (mag5),
        .sync_restart (1'b0),
        .period_start (ps5),
        .stream_out   (so5)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts one period from the current period start. Optionally changes the
    // magnitude in mid-period, and sets the next value in the last cycle.
    task automatic run_period(input logic [7:0] next_mag, input int mid_at,
                              input logic [7:0] mid_mag, output int ones,
                              output logic [255:0] bits);
        bit ps_bad = 1'b0;
        ones = 0;
        bits = '0;
        for (int i = 0; i < 256; i++) begin
            if (period_start !== (i == 0)) ps_bad = 1'b1;
            if (stream_out === 1'b1) begin
                ones++;
                bits[i] = 1'b1;
            end
            if (i == mid_at) magnitude = mid_mag;
            if (i == 255) magnitude = next_mag;
            @(negedge clk);
        end
        check(!ps_bad, "R6 period_start placement", int'(ps_bad), 0);
    endtask

    task automatic t_reset(output int ones);
        logic [255:0] bits;
        repeat (3) @(negedge clk);
        check(period_start === 1'b1 && stream_out === 1'b0, "R1 reset outputs",
              int'({period_start, stream_out}), 2);
        rst_n = 1'b1;
        run_period(8'hFF, -1, 8'h00, ones, bits);
        check(ones == 0, "R1 first period uses zero", ones, 0);
    endtask

    task automatic t_full_and_half();
        int ones;
        logic [255:0] bits;
        logic [255:0] exp_half;
        run_period(8'h80, -1, 8'h00, ones, bits);
        check(ones == 255 && bits[255] == 1'b0, "R3 all ones leaves last slot", ones, 255);
        run_period(8'h00, -1, 8'h00, ones, bits);
        for (int i = 0; i < 256; i++) exp_half[i] = (i % 2 == 0);
        check(bits == exp_half, "R4 half scale alternates", ones, 128);
        run_period(8'h01, -1, 8'h00, ones, bits);
        check(ones == 0, "R9 zero magnitude silent", ones, 0);
        run_period(8'h5A, -1, 8'h00, ones, bits);
        check(ones == 1 && bits[127] == 1'b1, "R5 lsb at position 127", ones, 1);
    endtask

    task automatic t_mid_change();
        int ones;
        logic [255:0] bits;
        run_period(8'h40, 100, 8'hC3, ones, bits);
        check(ones == 90, "R7 mid-period change ignored", ones, 90);
        magnitude = 8'h40;
    endtask

    task automatic t_next_and_restart();
        int ones;
        logic [255:0] bits;
        // The mid-period value was overwritten with 0x40 before the boundary.
        run_period(8'h40, -1, 8'h00, ones, bits);
        check(ones == 64, "R7 boundary value takes effect", ones, 64);
        repeat (37) @(negedge clk);
        check(period_start === 1'b0, "R8 mid-period before restart", int'(period_start), 0);
        magnitude = 8'h93;
        sync_restart = 1'b1;
        @(negedge clk);
        sync_restart = 1'b0;
        check(period_start === 1'b1, "R8 restart starts period", int'(period_start), 1);
        run_period(8'h00, -1, 8'h00, ones, bits);
        check(ones == 147, "R8 restart captures magnitude", ones, 147);
    endtask

    task automatic t_sweep();
        int ones;
        logic [255:0] bits;
        logic [255:0] exp_bits;
        for (int v = 0; v < 256; v++) begin
            run_period(8'(v + 1), -1, 8'h00, ones, bits);
            check(ones == v, "R2 popcount equals magnitude", ones, v);
            if ($countones(v) == 1) begin
                int sp;
                sp = 256 / v;
                for (int i = 0; i < 256; i++) exp_bits[i] = ((i % sp) == sp / 2 - 1);
                check(bits == exp_bits, "R5 even spacing", ones, v);
            end
        end
    endtask

    task automatic t_short_stream();
        bit ps_bad;
        int ones;
        while (ps5 !== 1'b1) @(negedge clk);
        for (int v = 0; v < 32; v++) begin
            ps_bad = 1'b0;
            ones = 0;
            for (int i = 0; i < 32; i++) begin
                if (ps5 !== (i == 0)) ps_bad = 1'b1;
                if (so5 === 1'b1) ones++;
                if (i == 31) mag5 = 5'(v + 1);
                @(negedge clk);
            end
            check(ones == v && !ps_bad, "R10 short stream count", ones, v);
        end
    endtask

    initial begin
        int ones;
        t_reset(ones);
        t_full_and_half();
        t_mid_change();
        t_next_and_restart();
        t_sweep();
        t_short_stream();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            check(1'b0, "watchdog", cycles, 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule